// File: doc/BRIEF.md
# Switch register access bridge

The bridge gives a host processor on a simple 32-bit register bus a path into a switch's internal register space, where each register is named by an 8-bit page and an 8-bit register number. The host first asks for ownership of the switch register port through a request bit in the control register. It then polls until the grant bit is set.

While it holds the grant, the host loads up to 64 bits of outgoing data into two 32-bit words. It then writes the command register with the page, the register number, the direction and the start bit. The start bit stays set while the switch works on the access. The switch answers with a one-cycle done pulse. On a read, that pulse also loads the 64-bit answer into two read-data words.

Narrow transfers are right-aligned in the low word. A 48-bit transfer uses only the lower 16 bits of the high word. A 64-bit transfer uses both full words. A reset bit in the command register aborts the access in flight and clears the bridge's data.

Top module: `sw_reg_bridge`

## Requirements
- R1: After reset, every mapped register reads zero, apart from the init-done bit, which follows `sw_init_done_i`. The grant is clear and `sw_start_o` is low.
- R2: The control register is at offset 0x40. Bit 3 is the request bit (read/write), bit 4 is the grant bit (read-only) and bit 6 is the init-done status (read-only). The grant rises one cycle after the stored request is seen, but only while `sw_owner_i` is low. Once the grant is held, `sw_owner_i` does not revoke it. The grant falls one cycle after the request is cleared.
- R3: The command register is at offset 0x2C. Its fields are page in bits 31:24, register number in bits 23:16, reset in bit 2, write in bit 1 (1 = write, 0 = read) and start/busy in bit 0. When the grant is held and no access is busy, writing bit 0 = 1 with bit 2 = 0 does three things: the start bit reads 1, `sw_start_o` pulses for exactly one cycle, and the page, register number and direction appear on the switch port.
- R4: A command write is ignored if the grant is not held, or if it is not a reset and an access is still busy. In both cases the command register reads back unchanged.
- R5: A done pulse during a busy access clears the start bit at that clock edge. On a read access, the same edge copies the 64-bit switch data into the read-data words: bits 63:32 to the high word at 0x38 and bits 31:0 to the low word at 0x3C.
- R6: The write-data high word (0x30) and low word (0x34) read back as written. They drive `sw_wdata_o` as {high, low}.
- R7: A granted command write with bit 2 = 1 does four things: it aborts any pending access, clears the start bit and command fields, and zeroes all four data words. Bit 2 reads 1 for exactly one cycle and then clears itself.
- R8: Offset 0x44 and every unmapped offset read zero. Host writes to the read-data words, the grant bit or the init-done bit have no effect.
- R9: A done pulse while no access is busy has no effect on the read-data words or on the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Host byte offset |
| bus_wr_i | input | 1 | Host write strobe |
| bus_rd_i | input | 1 | Host read strobe |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data, combinational, zero when not reading |
| sw_owner_i | input | 1 | Switch-side agent currently owns the register port |
| sw_init_done_i | input | 1 | Switch initialization finished |
| sw_start_o | output | 1 | One-cycle pulse launching a switch access |
| sw_page_o | output | 8 | Page of the access |
| sw_regnum_o | output | 8 | Register number of the access |
| sw_write_o | output | 1 | 1 for write access, 0 for read |
| sw_wdata_o | output | 64 | Outgoing data {high word, low word} |
| sw_done_i | input | 1 | Completion pulse from the switch |
| sw_rdata_i | input | 64 | Switch read data, valid with sw_done_i |

## Verification
Wrong busy state is visible on the first command read-back after the faulty edge. A stuck busy bit blocks every later start. A busy bit that clears early lets a second start pulse reach the switch. A grant that is late or never revoked shows up in the control read-back one cycle after the request changes. Faulty capture, or a faulty abort zeroing, appears in the data words at the first read after the done pulse or the reset write. A spurious done pulse, or a write to a read-only word, would change a value that should have held.

// File: rtl/sw_bridge_pkg.sv
package sw_bridge_pkg;
  localparam int unsigned AW      = 8;
  localparam int unsigned DW      = 32;
  localparam int unsigned SW_DW   = 2 * DW;
  localparam int unsigned PAGE_W  = 8;
  localparam int unsigned REG_W   = 8;

  localparam logic [AW-1:0] OFF_CMD  = 8'h2C;
  localparam logic [AW-1:0] OFF_WDH  = 8'h30;
  localparam logic [AW-1:0] OFF_WDL  = 8'h34;
  localparam logic [AW-1:0] OFF_RDH  = 8'h38;
  localparam logic [AW-1:0] OFF_RDL  = 8'h3C;
  localparam logic [AW-1:0] OFF_CTRL = 8'h40;
  localparam logic [AW-1:0] OFF_IRQ  = 8'h44;

  localparam int unsigned CMD_GO    = 0;
  localparam int unsigned CMD_WR    = 1;
  localparam int unsigned CMD_RST   = 2;
  localparam int unsigned CMD_REG   = 16;
  localparam int unsigned CMD_PAGE  = 24;
  localparam int unsigned CTL_REQ   = 3;
  localparam int unsigned CTL_GNT   = 4;
  localparam int unsigned CTL_INIT  = 6;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [REG_W-1:0]  regnum;
    logic              write;
  } sw_cmd_t;
endpackage

// File: rtl/sw_grant_ctrl.sv
module sw_grant_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic owner_i,
  output logic grant_o
);
  logic grant_q;

  // hold once granted; only acquire while switch side is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grant_q <= 1'b0;
    else         grant_q <= req_i & (grant_q | ~owner_i);
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/sw_cmd_engine.sv
module sw_cmd_engine
  import sw_bridge_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] cmd_wdata_i,
  input  logic          grant_i,
  input  logic          done_i,
  output logic          busy_o,
  output logic          rst_bit_o,
  output logic          abort_o,
  output logic          start_o,
  output logic          capture_o,
  output sw_cmd_t       cmd_o
);
  logic    busy_q, rst_q, start_q;
  sw_cmd_t cmd_q;
  logic    accept, launch;

  assign accept  = cmd_we_i & grant_i;
  assign abort_o = accept & cmd_wdata_i[CMD_RST];
  assign launch  = accept & ~busy_q & cmd_wdata_i[CMD_GO] & ~cmd_wdata_i[CMD_RST];
  assign capture_o = done_i & busy_q & ~cmd_q.write & ~abort_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rst_q   <= 1'b0;
      start_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      rst_q   <= abort_o;
      start_q <= launch;
      if (abort_o) begin
        busy_q <= 1'b0;
        cmd_q  <= '0;
      end else if (launch) begin
        busy_q       <= 1'b1;
        cmd_q.page   <= cmd_wdata_i[CMD_PAGE +: PAGE_W];
        cmd_q.regnum <= cmd_wdata_i[CMD_REG +: REG_W];
        cmd_q.write  <= cmd_wdata_i[CMD_WR];
      end else if (done_i && busy_q) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign rst_bit_o = rst_q;
  assign start_o   = start_q;
  assign cmd_o     = cmd_q;
endmodule

// File: rtl/sw_data_regs.sv
module sw_data_regs
  import sw_bridge_pkg::*;
#(
  parameter int unsigned WORDS = SW_DW / DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WORDS-1:0] wd_we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             abort_i,
  input  logic             capture_i,
  input  logic [SW_DW-1:0] sw_rdata_i,
  output logic [SW_DW-1:0] wd_o,
  output logic [SW_DW-1:0] rd_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] wd_q, rd_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wd_q <= '0;
        rd_q <= '0;
      end else if (abort_i) begin
        wd_q <= '0;
        rd_q <= '0;
      end else begin
        if (wd_we_i[w]) wd_q <= wdata_i;
        if (capture_i)  rd_q <= sw_rdata_i[w*DW +: DW];
      end
    end

    assign wd_o[w*DW +: DW] = wd_q;
    assign rd_o[w*DW +: DW] = rd_q;
  end
endmodule

// File: rtl/sw_reg_bridge.sv
module sw_reg_bridge
  import sw_bridge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic             sw_owner_i,
  input  logic             sw_init_done_i,
  output logic             sw_start_o,
  output logic [PAGE_W-1:0] sw_page_o,
  output logic [REG_W-1:0] sw_regnum_o,
  output logic             sw_write_o,
  output logic [SW_DW-1:0] sw_wdata_o,
  input  logic             sw_done_i,
  input  logic [SW_DW-1:0] sw_rdata_i
);
  logic             req_q, grant_q;
  logic             busy, rst_bit, abort, capture;
  sw_cmd_t          cmd;
  logic [SW_DW-1:0] wd, rd;
  logic [1:0]       wd_we;
  logic [DW-1:0]    mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else if (bus_wr_i && bus_addr_i == OFF_CTRL) req_q <= bus_wdata_i[CTL_REQ];
  end

  sw_grant_ctrl i_grant (
    .clk_i, .rst_ni,
    .req_i   (req_q),
    .owner_i (sw_owner_i),
    .grant_o (grant_q)
  );

  sw_cmd_engine i_cmd (
    .clk_i, .rst_ni,
    .cmd_we_i    (bus_wr_i && bus_addr_i == OFF_CMD),
    .cmd_wdata_i (bus_wdata_i),
    .grant_i     (grant_q),
    .done_i      (sw_done_i),
    .busy_o      (busy),
    .rst_bit_o   (rst_bit),
    .abort_o     (abort),
    .start_o     (sw_start_o),
    .capture_o   (capture),
    .cmd_o       (cmd)
  );

  assign wd_we = {bus_wr_i && bus_addr_i == OFF_WDH, bus_wr_i && bus_addr_i == OFF_WDL};

  sw_data_regs i_data (
    .clk_i, .rst_ni,
    .wd_we_i    (wd_we),
    .wdata_i    (bus_wdata_i),
    .abort_i    (abort),
    .capture_i  (capture),
    .sw_rdata_i (sw_rdata_i),
    .wd_o       (wd),
    .rd_o       (rd)
  );

  always_comb begin
    mux = '0;
    unique case (bus_addr_i)
      OFF_CMD: begin
        mux[CMD_PAGE +: PAGE_W] = cmd.page;
        mux[CMD_REG +: REG_W]   = cmd.regnum;
        mux[CMD_RST]            = rst_bit;
        mux[CMD_WR]             = cmd.write;
        mux[CMD_GO]             = busy;
      end
      OFF_WDH:  mux = wd[SW_DW-1:DW];
      OFF_WDL:  mux = wd[DW-1:0];
      OFF_RDH:  mux = rd[SW_DW-1:DW];
      OFF_RDL:  mux = rd[DW-1:0];
      OFF_CTRL: begin
        mux[CTL_REQ]  = req_q;
        mux[CTL_GNT]  = grant_q;
        mux[CTL_INIT] = sw_init_done_i;
      end
      default:  mux = '0; // includes interrupt capture word
    endcase
  end

  assign bus_rdata_o = bus_rd_i ? mux : '0;
  assign sw_page_o   = cmd.page;
  assign sw_regnum_o = cmd.regnum;
  assign sw_write_o  = cmd.write;
  assign sw_wdata_o  = wd;
endmodule

// File: rtl/sw_bridge_chk.sv
module sw_bridge_chk #(
  parameter int unsigned SW_DW = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req,
  input logic             grant,
  input logic             busy,
  input logic             start,
  input logic             rst_bit,
  input logic             done,
  input logic             abort,
  input logic             capture,
  input logic [SW_DW-1:0] rd
);
  assert_grant_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant |-> $past(req));
  assert_start_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !start);
  assert_start_while_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> busy);
  assert_busy_ends_on_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $past(done || abort));
  assert_rst_self_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_bit |=> !rst_bit);
  assert_abort_idles_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> !busy);
  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture && !abort) |=> $stable(rd));
endmodule

bind sw_reg_bridge sw_bridge_chk #(.SW_DW(sw_bridge_pkg::SW_DW)) i_chk (
  .clk_i, .rst_ni,
  .req     (req_q),
  .grant   (grant_q),
  .busy    (busy),
  .start   (sw_start_o),
  .rst_bit (rst_bit),
  .done    (sw_done_i),
  .abort   (abort),
  .capture (capture),
  .rd      (rd)
);

// File: tb/test_sw_reg_bridge.sv
module test_sw_reg_bridge;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = 0;
  logic        wr = 0, rd = 0;
  logic [31:0] wdata = 0, rdata;
  logic        owner = 0, init_done = 0, start, swr, done = 0;
  logic [7:0]  page, regnum;
  logic [63:0] swd, sw_rdata = 0;
  int          n_chk = 0, n_fail = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t q[$];
  event smp;

  always #4 clk = ~clk;

  sw_reg_bridge i_sw_reg_bridge (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sw_owner_i(owner),
    .sw_init_done_i(init_done), .sw_start_o(start), .sw_page_o(page),
    .sw_regnum_o(regnum), .sw_write_o(swr), .sw_wdata_o(swd),
    .sw_done_i(done), .sw_rdata_i(sw_rdata));

  // monitor: compare sampled read data against scoreboard head
  always @(smp) begin
    exp_t e;
    e = q.pop_front();
    n_chk++;
    if (rdata !== e.exp) begin
      n_fail++;
      $display("FAIL %s: read got %h expected %h", e.tag, rdata, e.exp);
    end
  end

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a negedge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    x.exp = e; x.tag = tag;
    q.push_back(x);
    addr = a; rd = 1;
    #2 -> smp;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic pulse_done(input logic [63:0] d);
    done = 1; sw_rdata = d;
    @(negedge clk);
    done = 0; sw_rdata = 64'h0;
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_rd(8'h2C, 32'h0, "R1 cmd");
    expect_rd(8'h40, 32'h0, "R1 ctrl");
    expect_rd(8'h3C, 32'h0, "R1 rd lo");
    check(start, 0, "R1 start");
    // R4 command without grant
    bus_write(8'h2C, 32'h0102_0001);
    check(start, 0, "R4 no grant start");
    expect_rd(8'h2C, 32'h0, "R4 no grant cmd");
    // R2 grant blocked by owner, then acquired
    owner = 1;
    bus_write(8'h40, 32'h0000_0008);
    expect_rd(8'h40, 32'h08, "R2 req only");
    expect_rd(8'h40, 32'h08, "R2 owner blocks");
    owner = 0;
    expect_rd(8'h40, 32'h08, "R2 same cycle");
    expect_rd(8'h40, 32'h18, "R2 granted");
    init_done = 1; owner = 1;
    expect_rd(8'h40, 32'h58, "R2 init and held grant");
    // R8 read-only ctrl bits
    bus_write(8'h40, 32'h0000_0008);
    expect_rd(8'h40, 32'h58, "R8 ctrl ro bits");
    // R6 write data
    bus_write(8'h30, 32'h0000_BEEF);
    bus_write(8'h34, 32'h1234_5678);
    expect_rd(8'h30, 32'h0000_BEEF, "R6 wd hi");
    expect_rd(8'h34, 32'h1234_5678, "R6 wd lo");
    // R3 write access launch
    bus_write(8'h2C, 32'h1234_0003);
    check(start, 1, "R3 start pulse");
    check({page, regnum, 7'h0, swr}, {8'h12, 8'h34, 8'h01}, "R3 fields");
    check(swd, 64'h0000_BEEF_1234_5678, "R6 sw wdata");
    expect_rd(8'h2C, 32'h1234_0003, "R3 busy");
    check(start, 0, "R3 pulse one cycle");
    // R4 command while busy
    bus_write(8'h2C, 32'h5566_0001);
    expect_rd(8'h2C, 32'h1234_0003, "R4 busy ignore");
    check(start, 0, "R4 no relaunch");
    // R5 done on write access
    pulse_done(64'hFFFF_FFFF_FFFF_FFFF);
    expect_rd(8'h2C, 32'h1234_0002, "R5 write done");
    expect_rd(8'h3C, 32'h0, "R5 write no capture");
    // R5 read access capture
    bus_write(8'h2C, 32'hA0B0_0001);
    check({page, regnum, 7'h0, swr}, {8'hA0, 8'hB0, 8'h00}, "R3 read fields");
    repeat (2) @(negedge clk);
    pulse_done(64'hCAFE_0001_8765_4321);
    expect_rd(8'h2C, 32'hA0B0_0000, "R5 read done");
    expect_rd(8'h38, 32'hCAFE_0001, "R5 rd hi");
    expect_rd(8'h3C, 32'h8765_4321, "R5 rd lo");
    // R9 stray done
    pulse_done(64'h1111_2222_3333_4444);
    expect_rd(8'h38, 32'hCAFE_0001, "R9 rd hi hold");
    expect_rd(8'h2C, 32'hA0B0_0000, "R9 cmd hold");
    // R8 read-only data words, irq and unmapped
    bus_write(8'h3C, 32'hFFFF_FFFF);
    expect_rd(8'h3C, 32'h8765_4321, "R8 rd lo ro");
    expect_rd(8'h44, 32'h0, "R8 irq zero");
    expect_rd(8'h50, 32'h0, "R8 unmapped");
    // R7 abort of a pending read
    bus_write(8'h2C, 32'h0102_0001);
    bus_write(8'h2C, 32'h0000_0004);
    expect_rd(8'h2C, 32'h0000_0004, "R7 rst bit set");
    expect_rd(8'h2C, 32'h0, "R7 rst cleared");
    expect_rd(8'h30, 32'h0, "R7 wd hi zero");
    expect_rd(8'h34, 32'h0, "R7 wd lo zero");
    expect_rd(8'h38, 32'h0, "R7 rd hi zero");
    pulse_done(64'h5555_6666_7777_8888);
    expect_rd(8'h3C, 32'h0, "R7 done after abort");
    // R2 release
    bus_write(8'h40, 32'h0);
    expect_rd(8'h40, 32'h50, "R2 grant lingers");
    expect_rd(8'h40, 32'h40, "R2 grant dropped");
    bus_write(8'h2C, 32'h0102_0001);
    check(start, 0, "R4 after release");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule